// File: doc/BRIEF.md
# I2C Start and Repeated-Start Condition Generator

This block produces the two bus conditions an I2C master needs to open a transfer: a START on an idle bus, and a repeated START on a bus it already owns. It drives open-drain enables for the SDA and SCL lines, where an enable of 1 pulls the line low and 0 lets it float high. It also samples the real line levels through two-flop synchronizers, so another device that holds SCL low simply delays the sequence.

Software raises a one-cycle start or restart pulse. A start request is latched and waits until the bus monitor reports the bus free. A restart request is honoured only when the bus is busy and this block is master. Otherwise it is dropped. Each timed phase of a sequence uses the programmed SCL high and low counts, in clock cycles, plus fixed setup and hold parameters. When a sequence ends the block reports master and transmit mode and pulses a done flag for one cycle.

Top module: `i2c_cond_gen`

## Requirements
- R1: While reset is high, and in the cycle after reset falls, both line enables are 0 and busy, master, transmit-mode and done are all 0.
- R2: A start request is held pending while busy is 1 and does nothing to the lines. With a request pending, SDA enable rises 4 cycles after the external SDA line rises with SCL high, which is the cycle after busy clears.
- R3: In a START, SDA enable rises first. SCL enable rises exactly hi + START_HOLD cycles later, where hi is the effective high count.
- R4: After SCL enable rises, and with SCL following it low, done rises lo + 3 cycles later. That figure is 2 synchronizer stages, 1 detection cycle and the lo-cycle low phase. Done, master and transmit-mode are then all 1.
- R5: A restart requested while busy and master first drops SDA enable. SCL enable falls lo cycles later. SDA enable rises lo + RS_SETUP + 3 cycles after SCL is high. SCL enable rises hi + RS_HOLD cycles after that. Done rises lo + 3 cycles after that. Busy stays 1 throughout.
- R6: A restart requested while the bus is free, or while the block is not master, is discarded. Neither enable changes and done stays 0. The discarded request does not fire later, even after the block becomes master.
- R7: While a sequence waits for an SCL level, it stalls for as long as another device holds SCL at the other level. The timed phase that follows starts only once the level is seen.
- R8: Busy becomes 1 three cycles after SDA falls while SCL is high. It becomes 0 three cycles after SDA rises while SCL is high.
- R9: A high or low count of 0 is treated as 1.
- R10: Done is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req_i | input | 1 | One-cycle request for a START |
| restart_req_i | input | 1 | One-cycle request for a repeated START |
| hi_cnt_i | input | 8 | SCL high-period count in cycles (0 acts as 1) |
| lo_cnt_i | input | 8 | SCL low-period count in cycles (0 acts as 1) |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | SCL pull-down enable (1 = drive low) |
| sda_oe_o | output | 1 | SDA pull-down enable (1 = drive low) |
| busy_o | output | 1 | Bus busy flag |
| master_o | output | 1 | Master mode flag |
| tx_mode_o | output | 1 | Transmit mode flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can coincide here: the bus monitor clearing busy when another master ends its transfer, and the sequencer acting on a start request that has been held pending the whole time. The bench models a foreign master holding SDA low with SCL high and issues a start request during that time. It then releases SDA and expects SDA enable to rise exactly four cycles later, with no earlier activity on either line. A restart issued while the foreign master owns the bus is checked the same way: it must leave no trace even after the block later wins the bus.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    localparam int unsigned CNT_W = 8;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_ST_HOLD,
        SQ_R_REL,
        SQ_R_WAIT_HI,
        SQ_R_SETUP,
        SQ_R_HOLD,
        SQ_WAIT_LO,
        SQ_LOW
    } seq_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pin_pair_t;

    function automatic logic [CNT_W-1:0] clamp_min1(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '1;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '1;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon
    import i2c_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_pair_t lvl,
    output logic      busy
);
    pin_pair_t prev;
    logic      cond_s, cond_p;

    assign cond_s = prev.scl & lvl.scl & prev.sda & ~lvl.sda;
    assign cond_p = prev.scl & lvl.scl & ~prev.sda & lvl.sda;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '{scl: 1'b1, sda: 1'b1};
            busy <= 1'b0;
        end else begin
            prev <= lvl;
            if (cond_s)      busy <= 1'b1;
            else if (cond_p) busy <= 1'b0;
        end
    end

    // R8
    busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(lvl.sda) == 1'b0 && $past(lvl.scl) == 1'b1));

    // R8
    busy_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(lvl.sda) == 1'b1 && $past(lvl.scl) == 1'b1));
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int unsigned START_HOLD = 4,
    parameter int unsigned RS_SETUP   = 5,
    parameter int unsigned RS_HOLD    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             restart_req,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  pin_pair_t        lvl,
    input  logic             busy_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             master_o,
    output logic             tx_mode_o,
    output logic             done_o
);
    localparam int unsigned EXTRA_A = (START_HOLD > RS_SETUP) ? START_HOLD : RS_SETUP;
    localparam int unsigned EXTRA   = (EXTRA_A > RS_HOLD) ? EXTRA_A : RS_HOLD;
    localparam int unsigned TMR_W   = $clog2((1 << CNT_W) + EXTRA + 1);

    seq_state_e       state;
    logic [TMR_W-1:0] tmr;
    logic [TMR_W-1:0] hi_t, lo_t;
    logic             st_pend, rs_pend, is_rs, tmr_last;

    assign hi_t     = TMR_W'(clamp_min1(hi_cnt));
    assign lo_t     = TMR_W'(clamp_min1(lo_cnt));
    assign tmr_last = (tmr == TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            tmr       <= '0;
            sda_oe    <= 1'b0;
            scl_oe    <= 1'b0;
            st_pend   <= 1'b0;
            rs_pend   <= 1'b0;
            is_rs     <= 1'b0;
            master_o  <= 1'b0;
            tx_mode_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tmr != '0) tmr <= tmr - TMR_W'(1);
            case (state)
                SQ_IDLE: begin
                    if (rs_pend) begin
                        if (busy_i && master_o) begin
                            state  <= SQ_R_REL;
                            is_rs  <= 1'b1;
                            sda_oe <= 1'b0;
                            tmr    <= lo_t;
                        end else begin
                            rs_pend <= 1'b0;
                        end
                    end else if (st_pend && !busy_i) begin
                        state  <= SQ_ST_HOLD;
                        is_rs  <= 1'b0;
                        sda_oe <= 1'b1;
                        tmr    <= hi_t + TMR_W'(START_HOLD);
                    end
                end
                SQ_ST_HOLD: begin
                    if (tmr_last) begin
                        scl_oe <= 1'b1;
                        state  <= SQ_WAIT_LO;
                    end
                end
                SQ_R_REL: begin
                    if (tmr_last) begin
                        scl_oe <= 1'b0;
                        state  <= SQ_R_WAIT_HI;
                    end
                end
                SQ_R_WAIT_HI: begin
                    if (lvl.scl) begin
                        state <= SQ_R_SETUP;
                        tmr   <= lo_t + TMR_W'(RS_SETUP);
                    end
                end
                SQ_R_SETUP: begin
                    if (tmr_last) begin
                        sda_oe <= 1'b1;
                        state  <= SQ_R_HOLD;
                        tmr    <= hi_t + TMR_W'(RS_HOLD);
                    end
                end
                SQ_R_HOLD: begin
                    if (tmr_last) begin
                        scl_oe <= 1'b1;
                        state  <= SQ_WAIT_LO;
                    end
                end
                SQ_WAIT_LO: begin
                    if (!lvl.scl) begin
                        state <= SQ_LOW;
                        tmr   <= lo_t;
                    end
                end
                SQ_LOW: begin
                    if (tmr_last) begin
                        state     <= SQ_IDLE;
                        done_o    <= 1'b1;
                        master_o  <= 1'b1;
                        tx_mode_o <= 1'b1;
                        if (is_rs) rs_pend <= 1'b0;
                        else       st_pend <= 1'b0;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
            if (start_req)   st_pend <= 1'b1;
            if (restart_req) rs_pend <= 1'b1;
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R4
    done_flags_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (master_o && tx_mode_o));

    // R3
    scl_after_sda_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> sda_oe);

    // R2
    start_when_free_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_ST_HOLD && $past(state) == SQ_IDLE) |-> !$past(busy_i));

    // R5
    restart_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_R_REL && $past(state) == SQ_IDLE) |-> $past(busy_i && master_o));

    // R7
    stall_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT_LO && lvl.scl) |=> (state == SQ_WAIT_LO));

    // R7
    stall_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_R_WAIT_HI && !lvl.scl) |=> (state == SQ_R_WAIT_HI && $stable(sda_oe)));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int unsigned START_HOLD  = 4,
    parameter int unsigned RS_SETUP    = 5,
    parameter int unsigned RS_HOLD     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req_i,
    input  logic             restart_req_i,
    input  logic [CNT_W-1:0] hi_cnt_i,
    input  logic [CNT_W-1:0] lo_cnt_i,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             master_o,
    output logic             tx_mode_o,
    output logic             done_o
);
    pin_pair_t raw_lvl, sync_lvl;

    assign raw_lvl = '{scl: scl_i, sda: sda_i};

    i2c_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_lvl),
        .q   (sync_lvl)
    );

    i2c_bus_mon u_mon (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lvl),
        .busy (busy_o)
    );

    i2c_cond_seq #(
        .START_HOLD (START_HOLD),
        .RS_SETUP   (RS_SETUP),
        .RS_HOLD    (RS_HOLD)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req_i),
        .restart_req (restart_req_i),
        .hi_cnt      (hi_cnt_i),
        .lo_cnt      (lo_cnt_i),
        .lvl         (sync_lvl),
        .busy_i      (busy_o),
        .scl_oe      (scl_oe_o),
        .sda_oe      (sda_oe_o),
        .master_o    (master_o),
        .tx_mode_o   (tx_mode_o),
        .done_o      (done_o)
    );
endmodule

// File: tb/test_i2c_cond_gen.sv
module test_i2c_cond_gen;
    localparam int START_HOLD = 4;
    localparam int RS_SETUP   = 5;
    localparam int RS_HOLD    = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, restart_req = 1'b0;
    logic [7:0] hi_cnt = 8'd10, lo_cnt = 8'd7;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic scl_oe, sda_oe, busy, master, tx_mode, done;
    logic scl_line, sda_line;
    int compared = 0, mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = ~(scl_oe | ext_scl_low);
    assign sda_line = ~(sda_oe | ext_sda_low);

    i2c_cond_gen #(.START_HOLD(START_HOLD), .RS_SETUP(RS_SETUP), .RS_HOLD(RS_HOLD)) i_i2c_cond_gen (
        .clk(clk), .rst(rst), .start_req_i(start_req), .restart_req_i(restart_req),
        .hi_cnt_i(hi_cnt), .lo_cnt_i(lo_cnt), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .master_o(master),
        .tx_mode_o(tx_mode), .done_o(done)
    );

    function automatic logic sig(input int sel);
        case (sel)
            0: return sda_oe;
            1: return scl_oe;
            2: return done;
            default: return busy;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_sig(input int sel, input logic v, output int n);
        n = 0;
        while (sig(sel) !== v && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext_scl_low = 1'b0; ext_sda_low = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic pulse_restart();
        @(negedge clk); restart_req = 1'b1;
        @(negedge clk); restart_req = 1'b0;
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic run_start(input string tag);
        int n;
        pulse_start();
        wait_sig(0, 1'b1, n);
        wait_sig(1, 1'b1, n);
        chk("R3", {tag, " sda->scl"}, n, eff(hi_cnt) + START_HOLD);
        wait_sig(2, 1'b1, n);
        chk("R4", {tag, " scl->done"}, n, eff(lo_cnt) + 3);
        chk("R4", {tag, " master"}, master, 1);
        chk("R4", {tag, " tx_mode"}, tx_mode, 1);
        @(negedge clk);
        chk("R10", {tag, " done width"}, done, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "oe during reset", {scl_oe, sda_oe}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "oe after reset", {scl_oe, sda_oe}, 0);
        chk("R1", "flags after reset", {busy, master, tx_mode, done}, 0);
    endtask

    task automatic t_start_restart();
        int n;
        do_reset();
        hi_cnt = 8'd10; lo_cnt = 8'd7;
        run_start("basic");
        chk("R8", "busy after own START", busy, 1);
        hi_cnt = 8'd6; lo_cnt = 8'd4;
        pulse_restart();
        wait_sig(0, 1'b0, n);
        wait_sig(1, 1'b0, n);
        chk("R5", "sda rel->scl rel", n, 4);
        wait_sig(0, 1'b1, n);
        chk("R5", "scl high->sda low", n, 4 + RS_SETUP + 3);
        chk("R5", "busy kept at Sr", busy, 1);
        wait_sig(1, 1'b1, n);
        chk("R5", "sda low->scl low", n, 6 + RS_HOLD);
        wait_sig(2, 1'b1, n);
        chk("R5", "restart done", n, 4 + 3);
        chk("R5", "busy after restart", busy, 1);
        @(negedge clk);
        chk("R10", "restart done width", done, 0);
    endtask

    task automatic t_stretch();
        int n;
        do_reset();
        hi_cnt = 8'd3; lo_cnt = 8'd5;
        run_start("pre-stretch");
        ext_scl_low = 1'b1;
        pulse_restart();
        wait_sig(1, 1'b0, n);
        repeat (20) @(negedge clk);
        chk("R7", "sda held while scl stretched", sda_oe, 0);
        chk("R7", "scl oe off while stretched", scl_oe, 0);
        ext_scl_low = 1'b0;
        wait_sig(0, 1'b1, n);
        chk("R7", "release->sda low", n, 5 + RS_SETUP + 3);
        wait_sig(2, 1'b1, n);
        chk("R7", "stretched restart completes", done, 1);
    endtask

    task automatic t_busy_block();
        int n;
        do_reset();
        hi_cnt = 8'd4; lo_cnt = 8'd4;
        ext_sda_low = 1'b1;
        wait_sig(3, 1'b1, n);
        chk("R8", "busy set latency", n, 3);
        pulse_start();
        pulse_restart();
        repeat (20) @(negedge clk);
        chk("R2", "pending START drives nothing", {scl_oe, sda_oe}, 0);
        chk("R6", "restart not master ignored", {scl_oe, sda_oe, done, master}, 0);
        ext_sda_low = 1'b0;
        wait_sig(0, 1'b1, n);
        chk("R2", "start after bus free", n, 4);
        chk("R8", "busy cleared before start", busy, 0);
        wait_sig(2, 1'b1, n);
        chk("R2", "pending START completes", master, 1);
        n = 0;
        repeat (40) begin
            @(negedge clk);
            if (!scl_oe || !sda_oe || done) n++;
        end
        chk("R6", "stale restart never fires", n, 0);
    endtask

    task automatic t_restart_free();
        int n;
        do_reset();
        hi_cnt = 8'd2; lo_cnt = 8'd2;
        pulse_restart();
        n = 0;
        repeat (30) begin
            @(negedge clk);
            if (scl_oe || sda_oe || done || master) n++;
        end
        chk("R6", "restart on free bus ignored", n, 0);
        run_start("after ignored restart");
        n = 0;
        repeat (40) begin
            @(negedge clk);
            if (!scl_oe || !sda_oe || done) n++;
        end
        chk("R6", "dropped restart stays dropped", n, 0);
    endtask

    task automatic t_min_counts();
        do_reset();
        hi_cnt = 8'd0; lo_cnt = 8'd0;
        run_start("R9 zero counts");
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_start_restart();
        t_stretch();
        t_busy_block();
        t_restart_free();
        t_min_counts();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule